// File: doc/BRIEF.md
# Clock controller register bank

This block is the software-visible configuration store of a clock control peripheral. It sits on a simple 32-bit bus with a word address, a write strobe and a read strobe. It holds the operating-mode word, two post-divider words, the control words of a main PLL and a secondary PLL, three clock-gating words and a power-management word. Every stored word drives a dedicated output, so downstream logic always sees the current configuration.

Each location has its own reset value and its own write mask. Bits outside a mask always read zero after a write. The mode word also has one bit that every write forces to one. One otherwise empty location returns a fixed constant.

Whenever a write changes clock configuration, a single-cycle `cfg_update` pulse tells a downstream frequency calculator to recompute its derived rates. The block also gives one pulse right after reset, so those derived values are valid from startup.

Top module: `clkctl_regbank`

## Requirements
- R1: While reset is asserted, and until the first write, the outputs show these values: mode 0x074B0B7B, divider0 0xFF870B48, divider1 0x49FCFE7F, main PLL 0x04001800, secondary PLL 0x04043001, all gating words 0xFFFFFFFF, power word 0x80209828. `rdata` and `cfg_update` are 0 during reset. The PLL fields are PD in bits 29:26, MFD in 25:16, MFI in 13:10 and MFN in 9:0. So the reset values are PD=1/MFD=0/MFI=6/MFN=0 and PD=1/MFD=4/MFI=12/MFN=1.
- R2: A write to word offset 0 (mode) stores `(wdata & 0x3B6FDFFF) | 0x04000000`, so bit 26 is always set.
- R3: A write to offset 1 (divider0) stores `wdata & 0xFF9F3FFF`. A write to offset 2 (divider1) stores the full word.
- R4: Writes to offset 4 (main PLL) and offset 6 (secondary PLL) store `wdata & 0xBFFF3FFF`.
- R5: Writes to offsets 8, 9 and 10 store the full word into gating words 0, 1 and 2. These writes raise no `cfg_update`.
- R6: A read of offset 18 returns 0x00004040. A read of any offset that is not mapped returns 0.
- R7: A write to offset 0, 1, 2, 4 or 6 makes `cfg_update` high for exactly the one cycle after the write edge. The new value is visible on the register output in that same cycle.
- R8: `cfg_update` is high for the single cycle after the first clock edge that follows reset release, with no write needed.
- R9: The power word at offset 23 is read-only. Writes to offset 23, to offset 18 and to unmapped offsets change no output and raise no `cfg_update`.
- R10: Read data is registered. `rdata` shows the addressed word in the cycle after a clock edge with `rd_en` high, and it holds its value while `rd_en` is low.
- R11: When a read and a write hit the same offset on the same edge, `rdata` returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (10) | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cfg_update | output | 1 | Recompute pulse |
| mode_o | output | 32 | Mode word |
| div0_o | output | 32 | Divider word 0 |
| div1_o | output | 32 | Divider word 1 |
| mpll_o | output | 32 | Main PLL control |
| spll_o | output | 32 | Secondary PLL control |
| gate_o | output | 32*N_GATE (96) | Gating words, word i in bits 32i+31:32i |
| pm_o | output | 32 | Power-management word |

## Verification
Every word is brought out on its own port, so a wrong mask bit, a lost forced bit or a misdecoded offset shows on a register output in the cycle right after the offending write. It does not wait for a later read. A wrong pulse condition shows on `cfg_update` in that same cycle. A stale or mis-selected read shows on `rdata` one cycle after the read strobe. A behavioural model that compares every output on every clock therefore catches any such fault within one cycle of the write or read that exposes it.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef logic [31:0] word_t;

  // Word offsets (software visible, fixed by the programming model)
  localparam int OFS_MODE  = 0;
  localparam int OFS_DIV0  = 1;
  localparam int OFS_DIV1  = 2;
  localparam int OFS_MPLL  = 4;
  localparam int OFS_SPLL  = 6;
  localparam int OFS_GATE0 = 8;
  localparam int OFS_ID    = 18;
  localparam int OFS_PM    = 23;

  // Bit 26 of the mode word is always set by a write
  localparam int    MODE_FORCE_BIT = 26;
  localparam word_t MODE_FORCE     = word_t'(1) << MODE_FORCE_BIT;

  localparam word_t MASK_MODE = 32'h3B6F_DFFF;
  localparam word_t MASK_DIV0 = 32'hFF9F_3FFF;
  localparam word_t MASK_FULL = 32'hFFFF_FFFF;
  localparam word_t MASK_PLL  = 32'hBFFF_3FFF;

  localparam word_t ID_CONST  = 32'h0000_4040;

  // Assemble a PLL control word from its fields
  function automatic word_t pll_word(input int pd, input int mfd, input int mfi, input int mfn);
    word_t w;
    w = '0;
    w[29:26] = 4'(pd);
    w[25:16] = 10'(mfd);
    w[13:10] = 4'(mfi);
    w[9:0]   = 10'(mfn);
    return w;
  endfunction

  localparam word_t RST_MODE = 32'h074B_0B7B;
  localparam word_t RST_DIV0 = 32'hFF87_0B48;
  localparam word_t RST_DIV1 = 32'h49FC_FE7F;
  localparam word_t RST_MPLL = pll_word(1, 0, 6, 0);
  localparam word_t RST_SPLL = pll_word(1, 4, 12, 1);
  localparam word_t RST_GATE = 32'hFFFF_FFFF;
  localparam word_t RST_PM   = 32'h8020_9828;

endpackage

// File: rtl/clkctl_dec.sv
module clkctl_dec
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_GATE = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mode,
  output logic              hit_div0,
  output logic              hit_div1,
  output logic              hit_mpll,
  output logic              hit_spll,
  output logic [N_GATE-1:0] hit_gate,
  output logic              hit_cfg
);

  always_comb begin
    hit_mode = (addr == ADDR_W'(OFS_MODE));
    hit_div0 = (addr == ADDR_W'(OFS_DIV0));
    hit_div1 = (addr == ADDR_W'(OFS_DIV1));
    hit_mpll = (addr == ADDR_W'(OFS_MPLL));
    hit_spll = (addr == ADDR_W'(OFS_SPLL));
    hit_cfg  = hit_mode | hit_div0 | hit_div1 | hit_mpll | hit_spll;
  end

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate_hit
    assign hit_gate[g] = (addr == ADDR_W'(OFS_GATE0 + g));
  end

  // R9: at most one storage location is selected
  always_comb begin
    if (!$isunknown(addr)) begin
      dec_onehot_chk: assert ($onehot0({hit_mode, hit_div0, hit_div1, hit_mpll, hit_spll, hit_gate}));
    end
  end

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
  import clkctl_pkg::*;
#(
  parameter word_t RST_VAL = '0,
  parameter word_t WR_MASK = '1,
  parameter word_t WR_SET  = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wdata,
  output word_t q
);

  word_t q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (we) q_d = (wdata & WR_MASK) | WR_SET;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else if (we) q_q <= q_d;
  end

  assign q = q_q;

  // R9: an unselected word never moves
  hold_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n) !we |=> $stable(q));

  // R3: bits outside the mask and the forced set read zero after a write
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~(WR_MASK | WR_SET)) == '0));

endmodule

// File: rtl/clkctl_rdmux.sv
module clkctl_rdmux
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_GATE = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  word_t                mode,
  input  word_t                div0,
  input  word_t                div1,
  input  word_t                mpll,
  input  word_t                spll,
  input  logic [32*N_GATE-1:0] gate,
  input  word_t                pm,
  output word_t                rd_word
);

  always_comb begin
    rd_word = '0;
    unique case (addr)
      ADDR_W'(OFS_MODE): rd_word = mode;
      ADDR_W'(OFS_DIV0): rd_word = div0;
      ADDR_W'(OFS_DIV1): rd_word = div1;
      ADDR_W'(OFS_MPLL): rd_word = mpll;
      ADDR_W'(OFS_SPLL): rd_word = spll;
      ADDR_W'(OFS_ID):   rd_word = ID_CONST;
      ADDR_W'(OFS_PM):   rd_word = pm;
      default:           rd_word = '0;
    endcase
    for (int i = 0; i < N_GATE; i++) begin
      if (addr == ADDR_W'(OFS_GATE0 + i)) rd_word = gate[32*i +: 32];
    end
  end

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int N_GATE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 cfg_update,
  output logic [31:0]          mode_o,
  output logic [31:0]          div0_o,
  output logic [31:0]          div1_o,
  output logic [31:0]          mpll_o,
  output logic [31:0]          spll_o,
  output logic [32*N_GATE-1:0] gate_o,
  output logic [31:0]          pm_o
);

  logic              hit_mode, hit_div0, hit_div1, hit_mpll, hit_spll, hit_cfg;
  logic [N_GATE-1:0] hit_gate;
  word_t             rd_word;

  clkctl_dec #(.ADDR_W(ADDR_W), .N_GATE(N_GATE)) u_dec (
    .addr     (addr),
    .hit_mode (hit_mode),
    .hit_div0 (hit_div0),
    .hit_div1 (hit_div1),
    .hit_mpll (hit_mpll),
    .hit_spll (hit_spll),
    .hit_gate (hit_gate),
    .hit_cfg  (hit_cfg)
  );

  clkctl_reg #(.RST_VAL(RST_MODE), .WR_MASK(MASK_MODE), .WR_SET(MODE_FORCE)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(wr_en & hit_mode), .wdata(wdata), .q(mode_o));

  clkctl_reg #(.RST_VAL(RST_DIV0), .WR_MASK(MASK_DIV0), .WR_SET('0)) u_div0 (
    .clk(clk), .rst_n(rst_n), .we(wr_en & hit_div0), .wdata(wdata), .q(div0_o));

  clkctl_reg #(.RST_VAL(RST_DIV1), .WR_MASK(MASK_FULL), .WR_SET('0)) u_div1 (
    .clk(clk), .rst_n(rst_n), .we(wr_en & hit_div1), .wdata(wdata), .q(div1_o));

  clkctl_reg #(.RST_VAL(RST_MPLL), .WR_MASK(MASK_PLL), .WR_SET('0)) u_mpll (
    .clk(clk), .rst_n(rst_n), .we(wr_en & hit_mpll), .wdata(wdata), .q(mpll_o));

  clkctl_reg #(.RST_VAL(RST_SPLL), .WR_MASK(MASK_PLL), .WR_SET('0)) u_spll (
    .clk(clk), .rst_n(rst_n), .we(wr_en & hit_spll), .wdata(wdata), .q(spll_o));

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    word_t gate_q;
    clkctl_reg #(.RST_VAL(RST_GATE), .WR_MASK(MASK_FULL), .WR_SET('0)) u_gate (
      .clk(clk), .rst_n(rst_n), .we(wr_en & hit_gate[g]), .wdata(wdata), .q(gate_q));
    assign gate_o[32*g +: 32] = gate_q;
  end

  // Power-management word has no write path
  assign pm_o = RST_PM;

  clkctl_rdmux #(.ADDR_W(ADDR_W), .N_GATE(N_GATE)) u_rdmux (
    .addr(addr), .mode(mode_o), .div0(div0_o), .div1(div1_o), .mpll(mpll_o),
    .spll(spll_o), .gate(gate_o), .pm(pm_o), .rd_word(rd_word));

  // Read data and update pulse
  word_t rdata_q, rdata_d;
  logic  init_q, init_d;
  logic  upd_q, upd_d;

  always_comb begin
    rdata_d = rd_en ? rd_word : rdata_q;
    init_d  = 1'b1;
    upd_d   = ~init_q | (wr_en & hit_cfg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      init_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rdata_d;
      init_q <= init_d;
      upd_q  <= upd_d;
    end
  end

  assign rdata      = rdata_q;
  assign cfg_update = upd_q;

  // R7
  cfg_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_cfg) |=> cfg_update);

  // R5
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !(wr_en && hit_cfg)) |=> !cfg_update);

  // R8
  boot_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |=> cfg_update);

  // R2
  mode_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_mode) |=> mode_o[MODE_FORCE_BIT]);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/clkctl_regbank_tb.sv
module clkctl_regbank_tb;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata, mode_o, div0_o, div1_o, mpll_o, spll_o, pm_o;
  logic [95:0]   gate_o;
  logic          cfg_update;

  always #10 clk = ~clk;  // 50 MHz

  clkctl_regbank #(.ADDR_W(AW), .N_GATE(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cfg_update(cfg_update), .mode_o(mode_o),
    .div0_o(div0_o), .div1_o(div1_o), .mpll_o(mpll_o), .spll_o(spll_o),
    .gate_o(gate_o), .pm_o(pm_o));

  // Behavioural reference state
  logic [31:0] m_mode, m_div0, m_div1, m_mpll, m_spll, m_pm;
  logic [31:0] m_gate [3];
  logic [31:0] e_rdata;
  logic        e_upd;
  bit          m_started;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;

  task automatic model_reset();
    m_mode = 32'h074B0B7B; m_div0 = 32'hFF870B48; m_div1 = 32'h49FCFE7F;
    m_mpll = 32'h04001800; m_spll = 32'h04043001; m_pm = 32'h80209828;
    foreach (m_gate[i]) m_gate[i] = 32'hFFFFFFFF;
    e_rdata = 32'h0; e_upd = 1'b0; m_started = 0;
  endtask

  function automatic logic [31:0] model_read(int a);
    case (a)
      0: return m_mode;
      1: return m_div0;
      2: return m_div1;
      4: return m_mpll;
      6: return m_spll;
      8, 9, 10: return m_gate[a-8];
      18: return 32'h00004040;
      23: return m_pm;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_cfg(int a);
    return (a == 0 || a == 1 || a == 2 || a == 4 || a == 6);
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    case (a)
      0: m_mode = (d & 32'h3B6FDFFF) | 32'h04000000;
      1: m_div0 = d & 32'hFF9F3FFF;
      2: m_div1 = d;
      4: m_mpll = d & 32'hBFFF3FFF;
      6: m_spll = d & 32'hBFFF3FFF;
      8, 9, 10: m_gate[a-8] = d;
      default: ;
    endcase
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%08h expected=%08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string rtag);
    cmp((rtag == "") ? "R2" : rtag, "mode", mode_o, m_mode);
    cmp((rtag == "") ? "R3" : rtag, "div0", div0_o, m_div0);
    cmp((rtag == "") ? "R3" : rtag, "div1", div1_o, m_div1);
    cmp((rtag == "") ? "R4" : rtag, "mpll", mpll_o, m_mpll);
    cmp((rtag == "") ? "R4" : rtag, "spll", spll_o, m_spll);
    for (int i = 0; i < 3; i++) cmp((rtag == "") ? "R5" : rtag, "gate", gate_o[32*i +: 32], m_gate[i]);
    cmp((rtag == "") ? "R9" : rtag, "pm", pm_o, m_pm);
    cmp((rtag == "") ? "R6/R10" : rtag, "rdata", rdata, e_rdata);
    cmp((rtag == "") ? "R7/R8" : rtag, "cfg_update", {31'b0, cfg_update}, {31'b0, e_upd});
  endtask

  // One bus cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic step(bit w, bit r, int a, logic [31:0] d);
    wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
    if (r) e_rdata = model_read(a);      // R11: read sees pre-write state
    e_upd = !m_started || (w && is_cfg(a));
    m_started = 1;
    if (w) model_write(a, d);
    @(posedge clk);
    @(negedge clk);
    compare_all("");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int offs[14];
    offs = '{0, 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 18, 23, 1023};
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    model_reset();
    repeat (3) begin
      @(negedge clk);
      compare_all("R1");  // reset values
    end
    rst_n = 1'b1;
    // R8: boot pulse after the first edge, then idle
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R1: read every location before any write
    foreach (offs[i]) step(0, 1, offs[i], 0);
    // R2 R3 R4 R5 R7: all-ones and all-zeros through each mask
    foreach (offs[i]) begin
      step(1, 0, offs[i], 32'hFFFFFFFF);
      step(0, 1, offs[i], 0);
      step(1, 0, offs[i], 32'h00000000);
      step(0, 1, offs[i], 0);
      step(1, 1, offs[i], 32'hA5C3_5A3C);  // R11 same-edge read/write
      step(0, 0, offs[i], 0);              // R10 hold
    end
    // R9: writes to read-only and unmapped offsets
    step(1, 0, 23, 32'h0);
    step(1, 0, 18, 32'h12345678);
    step(1, 0, 3, 32'hFFFFFFFF);
    step(0, 1, 23, 0);
    step(0, 1, 18, 0);
    // R6: unmapped read returns zero
    step(0, 1, 1023, 0);
    // Mixed traffic
    for (int k = 0; k < 2000; k++) begin
      int a;
      a = offs[$urandom_range(13, 0)];
      step(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), a, $urandom());
    end
    // R8: a second reset gives a fresh boot pulse
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0;
    model_reset();
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule